// File: doc/BRIEF.md
# Single-Precision Subtract Exception Flag Unit

This unit reports which IEEE-754 exceptions would arise from subtracting one single-precision operand from another. It does not return the difference. It returns an integer word in which each raised exception sets one bit. Denormal operands are first replaced by zero, and that replacement raises a flag of its own. A difference that would fall in the denormal range is likewise treated as zero and flagged. Rounding follows a two-bit mode input. Rounding can decide whether a result near the top of the range overflows.

The pipeline takes one operation per clock and produces the result a fixed three cycles after issue. A destination tag travels with each operation. Bit 0 of a guard word travels with it as well and becomes the write-enable that goes out with the result. A cleared guard leaves the destination untouched, but the flag word is still produced.

Top module: `fsub_flag_unit`

## Requirements
- R1: In the flag word, bit 1 is inexact, bit 2 is underflow, bit 3 is overflow, bit 4 is invalid, bit 5 is input-flushed and bit 6 is output-flushed. Bit 0 (divide by zero) and bits 31 to 7 are always 0.
- R2: Each operation accepted with `in_valid` high produces exactly one `out_valid` pulse three clock edges later, carrying its `in_tag`. The unit accepts operations on consecutive cycles, and results leave in issue order.
- R3: `out_we` equals bit 0 of the guard issued with the operation, and it is high only together with `out_valid`. Guard bits 31 to 1 have no effect.
- R4: An operand with a zero exponent field and a nonzero fraction is treated as zero and sets bit 5. This holds even when the other operand is a NaN.
- R5: A nonzero difference whose normalized exponent is below the smallest normal exponent is flushed to zero and sets bit 6. When the difference is exact, bit 6 is the only flag set.
- R6: A signaling NaN operand (exponent all ones, fraction nonzero, fraction MSB 0) sets bit 4. Infinity minus an infinity of the same sign sets bit 4. Infinity minus an infinity of the opposite sign sets no arithmetic flag.
- R7: A quiet NaN operand (fraction MSB 1) combined with a non-signaling second operand sets no arithmetic flag.
- R8: A finite difference whose rounded magnitude reaches exponent 255 sets bits 3 and 1 (0x0A).
- R9: A finite, non-overflowing, non-tiny difference sets bit 1 exactly when it cannot be represented exactly. Exact differences give 0.
- R10: Rounding mode `rmode` uses 0 for nearest-even, 1 for toward minus infinity, 2 for toward plus infinity and 3 for toward zero. A difference lying halfway above the largest finite magnitude overflows (0x0A) in nearest-even mode and in the directed mode pointing away from zero. In toward-zero mode and in the directed mode pointing toward zero, it gives inexact only (0x02).
- R11: Equal operands give a zero difference with no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| op_a | input | 32 | Minuend, single precision |
| op_b | input | 32 | Subtrahend, single precision |
| guard | input | 32 | Guard word; only bit 0 is used |
| rmode | input | 2 | Rounding mode |
| in_tag | input | TAG_W | Destination tag |
| out_valid | output | 1 | Result present |
| out_flags | output | 32 | Exception flag word |
| out_we | output | 1 | Destination write-enable |
| out_tag | output | TAG_W | Tag of the result |

## Verification
Each result is due at the third rising edge after the edge that samples its inputs. The driver applies operands on a falling edge. It records the expected flag word, write-enable and tag together with a due cycle three edges ahead. The monitor samples on falling edges only. It flags any result that appears in a different cycle from its due cycle, any expected result that fails to appear by its due cycle, and any result that arrives with no expected entry waiting. Back-to-back issues and issues separated by idle cycles are both covered, so the three-cycle spacing is checked with and without gaps.

// File: rtl/fsub_flag_unit.sv
module fsub_flag_unit #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      op_a,
  input  logic [31:0]      op_b,
  input  logic [31:0]      guard,
  input  logic [1:0]       rmode,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [31:0]      out_flags,
  output logic             out_we,
  output logic [TAG_W-1:0] out_tag
);
  localparam int BIT_INX = 1;
  localparam int BIT_UNF = 2;
  localparam int BIT_OVF = 3;
  localparam int BIT_INV = 4;
  localparam int BIT_IFZ = 5;
  localparam int BIT_OFZ = 6;
  localparam int MW = 27;

  logic [7:0]  ea, eb;
  logic [22:0] fa, fb;
  assign ea = op_a[30:23];
  assign eb = op_b[30:23];
  assign fa = op_a[22:0];
  assign fb = op_b[22:0];

  logic a_den, b_den, a_nan, b_nan, a_inf, b_inf;
  assign a_den = (ea == 8'h00) && (fa != 23'd0);
  assign b_den = (eb == 8'h00) && (fb != 23'd0);
  assign a_nan = (ea == 8'hff) && (fa != 23'd0);
  assign b_nan = (eb == 8'hff) && (fb != 23'd0);
  assign a_inf = (ea == 8'hff) && (fa == 23'd0);
  assign b_inf = (eb == 8'hff) && (fb == 23'd0);

  logic d_spec, d_inv;
  assign d_spec = a_nan | b_nan | a_inf | b_inf;
  assign d_inv  = (a_nan & ~fa[22]) | (b_nan & ~fb[22]) |
                  (a_inf & b_inf & (op_a[31] == op_b[31]));

  logic [23:0] ma, mb;
  logic        sb_eff;
  assign ma     = (ea != 8'h00) ? {1'b1, fa} : 24'd0;
  assign mb     = (eb != 8'h00) ? {1'b1, fb} : 24'd0;
  assign sb_eff = ~op_b[31];

  logic        swap;
  logic [7:0]  xe, ye, dexp;
  logic [23:0] xm, ym;
  logic        xs, ys;
  assign swap = {eb, mb} > {ea, ma};
  assign xe   = swap ? eb : ea;
  assign ye   = swap ? ea : eb;
  assign xm   = swap ? mb : ma;
  assign ym   = swap ? ma : mb;
  assign xs   = swap ? sb_eff : op_a[31];
  assign ys   = swap ? op_a[31] : sb_eff;
  assign dexp = xe - ye;

  logic [MW-1:0] y_ext, y_sh, y_lost, y_al;
  always_comb begin
    y_ext  = {ym, 3'b000};
    y_sh   = '0;
    y_lost = '0;
    if (dexp >= 8'(MW)) begin
      y_al = {{(MW-1){1'b0}}, |ym};
    end else begin
      y_sh   = y_ext >> dexp;
      y_lost = y_ext & ~({MW{1'b1}} << dexp);
      y_al   = {y_sh[MW-1:1], y_sh[0] | (|y_lost)};
    end
  end

  logic             s1_v, s1_we, s1_ifz, s1_spec, s1_inv, s1_sign, s1_sub;
  logic [TAG_W-1:0] s1_tag;
  logic [1:0]       s1_rm;
  logic [7:0]       s1_e;
  logic [MW-1:0]    s1_mx, s1_my;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_valid;

  always_ff @(posedge clk) begin
    s1_we   <= guard[0];
    s1_tag  <= in_tag;
    s1_rm   <= rmode;
    s1_ifz  <= a_den | b_den;
    s1_spec <= d_spec;
    s1_inv  <= d_inv;
    s1_sign <= xs;
    s1_sub  <= xs != ys;
    s1_e    <= xe;
    s1_mx   <= {xm, 3'b000};
    s1_my   <= y_al;
  end

  logic [MW:0] sum;
  assign sum = s1_sub ? ({1'b0, s1_mx} - {1'b0, s1_my})
                      : ({1'b0, s1_mx} + {1'b0, s1_my});

  logic [4:0] lz;
  always_comb begin
    lz = 5'd0;
    for (int i = 0; i < MW; i++)
      if (sum[i]) lz = 5'(MW - 1 - i);
  end

  logic [MW-1:0]     n_m;
  logic signed [9:0] n_e;
  always_comb begin
    if (sum[MW]) begin
      n_m = {sum[MW:2], sum[1] | sum[0]};
      n_e = $signed({2'b00, s1_e}) + 10'sd1;
    end else begin
      n_m = sum[MW-1:0] << lz;
      n_e = $signed({2'b00, s1_e}) - $signed({5'd0, lz});
    end
  end

  logic             s2_v, s2_we, s2_ifz, s2_spec, s2_inv, s2_sign, s2_zero;
  logic [TAG_W-1:0] s2_tag;
  logic [1:0]       s2_rm;
  logic [MW-1:0]    s2_m;
  logic signed [9:0] s2_e;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s2_v <= 1'b0;
    else        s2_v <= s1_v;

  always_ff @(posedge clk) begin
    s2_we   <= s1_we;
    s2_tag  <= s1_tag;
    s2_rm   <= s1_rm;
    s2_ifz  <= s1_ifz;
    s2_spec <= s1_spec;
    s2_inv  <= s1_inv;
    s2_sign <= s1_sign;
    s2_zero <= sum == '0;
    s2_m    <= n_m;
    s2_e    <= n_e;
  end

  logic lost, up;
  assign lost = |s2_m[2:0];
  always_comb begin
    case (s2_rm)
      2'd0:    up = s2_m[2] & (s2_m[1] | s2_m[0] | s2_m[3]);
      2'd1:    up = s2_sign & lost;
      2'd2:    up = ~s2_sign & lost;
      default: up = 1'b0;
    endcase
  end

  logic [24:0]       rnd;
  logic signed [9:0] r_e;
  logic              tiny, ovf;
  assign rnd  = {1'b0, s2_m[MW-1:3]} + 25'(up);
  assign r_e  = rnd[24] ? s2_e + 10'sd1 : s2_e;
  assign tiny = s2_e < 10'sd1;
  assign ovf  = r_e >= 10'sd255;

  logic [31:0] fl;
  always_comb begin
    fl = '0;
    fl[BIT_IFZ] = s2_ifz;
    if (s2_spec) begin
      fl[BIT_INV] = s2_inv;
    end else if (!s2_zero) begin
      if (tiny) begin
        fl[BIT_OFZ] = 1'b1;
        fl[BIT_UNF] = lost;
        fl[BIT_INX] = lost;
      end else if (ovf) begin
        fl[BIT_OVF] = 1'b1;
        fl[BIT_INX] = 1'b1;
      end else begin
        fl[BIT_INX] = lost;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_flags <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= s2_v;
      out_we    <= s2_v & s2_we;
      out_flags <= fl;
      out_tag   <= s2_tag;
    end
endmodule

// File: rtl/fsub_flag_unit_chk.sv
module fsub_flag_unit_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      guard,
  input logic [TAG_W-1:0] in_tag,
  input logic             out_valid,
  input logic             out_we,
  input logic [31:0]      out_flags,
  input logic [TAG_W-1:0] out_tag
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[31:7] == '0) && !out_flags[0]);                // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);                                            // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));                                      // R2
  AST_TAG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 (out_tag == $past(in_tag, 3)));                        // R2
  AST_WE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 (out_we == $past(guard[0], 3)));                       // R3
  AST_WE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);                                                  // R3
  AST_OVF_INX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[3]) |-> out_flags[1]);                          // R8
  AST_OFZ_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[6]) |-> !out_flags[3]);                         // R5
endmodule

bind fsub_flag_unit fsub_flag_unit_chk #(.TAG_W(TAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .guard(guard),
  .in_tag(in_tag), .out_valid(out_valid), .out_we(out_we),
  .out_flags(out_flags), .out_tag(out_tag)
);

// File: tb/fsub_flag_unit_test.sv
module fsub_flag_unit_test;
  localparam int TAG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [31:0]      op_a = '0, op_b = '0, guard = '0;
  logic [1:0]       rmode = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_valid, out_we;
  logic [31:0]      out_flags;
  logic [TAG_W-1:0] out_tag;

  fsub_flag_unit #(.TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .guard(guard), .rmode(rmode), .in_tag(in_tag), .out_valid(out_valid),
    .out_flags(out_flags), .out_we(out_we), .out_tag(out_tag)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0]      flags;
    logic             we;
    logic [TAG_W-1:0] tag;
    int               due;
    string            req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  logic [TAG_W-1:0] next_tag = '0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] g, input logic [1:0] rm,
                       input logic [31:0] eflags, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; guard = g; rmode = rm; in_tag = next_tag;
    e.flags = eflags; e.we = g[0]; e.tag = next_tag; e.due = cyc + 3; e.req = req;
    q.push_back(e);
    next_tag = next_tag + 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 32'hdeadbeef; op_b = 32'h12345678; guard = 32'h1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected result", 32'(out_tag), 32'hffffffff);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.due, "R2", "arrival cycle", 32'(cyc), 32'(e.due));
          check(out_tag == e.tag, "R2", "tag", 32'(out_tag), 32'(e.tag));
          check(out_flags == e.flags, e.req, "flags", out_flags, e.flags);
          check(out_we == e.we, "R3", "write-enable", 32'(out_we), 32'(e.we));
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        check(1'b0, "R2", "missing result", 32'(cyc), 32'(q[0].due));
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R2", "reset out_valid", 32'(out_valid), 32'h0);
    check(out_we == 1'b0, "R3", "reset out_we", 32'(out_we), 32'h0);
    check(out_flags == '0, "R1", "reset flags", out_flags, 32'h0);
    rst_n = 1'b1;
    idle(2);
    // R9 exact differences, back to back
    issue(32'h40400000, 32'h3f800000, 32'h1, 2'd0, 32'h00, "R9");
    issue(32'hc0400000, 32'h3f800000, 32'h1, 2'd0, 32'h00, "R9");
    issue(32'h40400000, 32'hc0400000, 32'h1, 2'd0, 32'h00, "R9");
    issue(32'h3f800000, 32'h33800000, 32'h1, 2'd0, 32'h00, "R9");
    issue(32'h3f800000, 32'h33000000, 32'h1, 2'd3, 32'h02, "R9");
    // R3 guard bit 0 only
    issue(32'h40400000, 32'h00800000, 32'h0, 2'd0, 32'h02, "R3");
    issue(32'h40400000, 32'h00800000, 32'h1, 2'd0, 32'h02, "R9");
    issue(32'h40400000, 32'h00800000, 32'hfffffffe, 2'd0, 32'h02, "R3");
    idle(2);
    // R4 input flush
    issue(32'h40400000, 32'h00400000, 32'h1, 2'd0, 32'h20, "R4");
    issue(32'h00400000, 32'h00200000, 32'h1, 2'd0, 32'h20, "R4");
    issue(32'h00000001, 32'h7f800001, 32'h1, 2'd0, 32'h30, "R4");
    // R5 output flush
    issue(32'h00c00000, 32'h00800000, 32'h1, 2'd0, 32'h40, "R5");
    issue(32'h80c00000, 32'h80800000, 32'h1, 2'd0, 32'h40, "R5");
    idle(1);
    // R6 invalid, R7 quiet NaN
    issue(32'h7f800000, 32'h7f800000, 32'h1, 2'd0, 32'h10, "R6");
    issue(32'hff800000, 32'hff800000, 32'h1, 2'd0, 32'h10, "R6");
    issue(32'h7f800000, 32'hff800000, 32'h1, 2'd0, 32'h00, "R6");
    issue(32'hffbfffff, 32'h3f800000, 32'h1, 2'd0, 32'h10, "R6");
    issue(32'h3f800000, 32'h7f800001, 32'h1, 2'd0, 32'h10, "R6");
    issue(32'hffffffff, 32'h3f800000, 32'h1, 2'd0, 32'h00, "R7");
    issue(32'h3f800000, 32'h7fc00000, 32'h1, 2'd0, 32'h00, "R7");
    // R8 overflow
    issue(32'h7f7fffff, 32'hff7fffff, 32'h1, 2'd0, 32'h0a, "R8");
    issue(32'hff7fffff, 32'h7f7fffff, 32'h1, 2'd3, 32'h0a, "R8");
    idle(3);
    // R10 rounding mode decides overflow at the halfway point
    issue(32'h7f7fffff, 32'hf3000000, 32'h1, 2'd0, 32'h0a, "R10");
    issue(32'h7f7fffff, 32'hf3000000, 32'h1, 2'd1, 32'h02, "R10");
    issue(32'h7f7fffff, 32'hf3000000, 32'h1, 2'd2, 32'h0a, "R10");
    issue(32'h7f7fffff, 32'hf3000000, 32'h1, 2'd3, 32'h02, "R10");
    issue(32'hff7fffff, 32'h73000000, 32'h1, 2'd0, 32'h0a, "R10");
    issue(32'hff7fffff, 32'h73000000, 32'h1, 2'd1, 32'h0a, "R10");
    issue(32'hff7fffff, 32'h73000000, 32'h1, 2'd2, 32'h02, "R10");
    issue(32'hff7fffff, 32'h73000000, 32'h1, 2'd3, 32'h02, "R10");
    // R11 zero differences
    issue(32'h40400000, 32'h40400000, 32'h1, 2'd0, 32'h00, "R11");
    issue(32'h00000000, 32'h80000000, 32'h1, 2'd1, 32'h00, "R11");
    issue(32'h00800000, 32'h00800000, 32'h1, 2'd2, 32'h00, "R11");
    idle(8);
    check(q.size() == 0, "R2", "results outstanding", 32'(q.size()), 32'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule